// File: doc/BRIEF.md
# Debounced Button HID Reporter

This block watches four active-low push buttons: volume up, volume down, playback mute and record mute. It filters each one through its own debouncer, which counts a millisecond tick. A debouncer accepts a new level only after the raw input has held that level for a full qualification window. Each accepted press or release updates a button status byte. It also queues a three-byte upstream report for an interrupt endpoint. The report is made of the status byte and two bytes that an external register interface writes.

A host-side poller reads `rpt_data` while `rpt_pending` is high, and pulses `host_poll` to take the report. Only one report is ever outstanding. A newer event overwrites a report that has not yet been taken. The block also drives three outputs:
- a record-mute indicator, which each accepted record-mute press toggles;
- an activity LED, which blinks with a 256 ms period while audio streaming is active;
- a remote-wakeup request, raised when a button is pressed while the device is suspended.

Top module: `btn_hid_reporter`

## Requirements
- R1: After synchronous reset, `rpt_pending`, `rpt_data`, `rec_mute_led`, `act_led` and `wake_req` are all 0.
- R2: A button level change is accepted only after the raw input has differed from the accepted level for DEBOUNCE_MS consecutive `ms_tick` pulses (default 64). A shorter glitch changes neither the status byte nor `rpt_pending`.
- R3: Status byte encoding: bit0 = volume up, bit1 = volume down, bit2 = playback mute, bit3 = record mute. A bit is 1 while its debounced button is held. Bits 7:4 are always 0. Button i is `btn_n[i]`, active low.
- R4: Every accepted press and every accepted release queues a report (`rpt_pending` = 1 on the following cycle).
- R5: A register write with `reg_wr_odd` = 0 stores `reg_wr_data` as the even byte, and with `reg_wr_odd` = 1 as the odd byte. Every write queues a report.
- R6: Report layout: `rpt_data[7:0]` is the status byte, `rpt_data[15:8]` the even register byte, and `rpt_data[23:16]` the odd register byte. All three hold their values as of the event that queued the report.
- R7: A queued report stays pending until `host_poll`. A poll with no new event in the same cycle clears `rpt_pending`. An event in the same cycle as a poll leaves the report pending with the new contents. A later event overwrites an unpolled report.
- R8: Each accepted record-mute press toggles `rec_mute_led`. A release does not change it.
- R9: `act_led` is 0 while `stream_active` is 0. While it is 1, the LED toggles every BLINK_HALF_MS ticks (default 128), which gives a 256 ms period.
- R10: An accepted press while `suspended` = 1 sets `wake_req`. The request stays set until `suspended` falls. A press while not suspended does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| btn_n | input | 4 | Raw active-low buttons: vol up, vol down, play mute, rec mute |
| reg_wr_en | input | 1 | Register byte write strobe |
| reg_wr_odd | input | 1 | 0 selects the even byte, 1 selects the odd byte |
| reg_wr_data | input | 8 | Register byte value |
| host_poll | input | 1 | Poller takes the pending report |
| suspended | input | 1 | Device is in suspend |
| stream_active | input | 1 | Playback or recording is running |
| rpt_pending | output | 1 | A report is waiting for the poller |
| rpt_data | output | 24 | Report: {odd byte, even byte, status} |
| rec_mute_led | output | 1 | Record-mute indicator |
| act_led | output | 1 | Activity blink LED |
| wake_req | output | 1 | Remote-wakeup request |

## Verification
The functions that can meet in one cycle are the taking of a report by the poller and the queueing of a new one. A register write can also land in the same cycle as an accepted button edge. The bench drives `host_poll` and `reg_wr_en` on the same clock edge while a report is pending. It then expects `rpt_pending` to remain high and the new byte to appear in the report. A second, lone poll must then clear it. Random button toggles and register writes, checked against a bench model of status, register bytes and mute state, cover button edges combined with earlier writes.

// File: rtl/btn_hid_pkg.sv
package btn_hid_pkg;

    localparam int NUM_BTN  = 4;
    localparam int BTN_VUP  = 0;
    localparam int BTN_VDN  = 1;
    localparam int BTN_PMUT = 2;
    localparam int BTN_RMUT = 3;

    typedef struct packed {
        logic [7:0] odd_byte;
        logic [7:0] even_byte;
        logic [7:0] status;
    } hid_report_t;

    function automatic logic [7:0] status_of(input logic [NUM_BTN-1:0] held);
        logic [7:0] s;
        s = '0;
        s[NUM_BTN-1:0] = held;
        return s;
    endfunction

    function automatic hid_report_t pack_report(input logic [NUM_BTN-1:0] held,
                                                input logic [7:0] ev,
                                                input logic [7:0] od);
        hid_report_t r;
        r.status    = status_of(held);
        r.even_byte = ev;
        r.odd_byte  = od;
        return r;
    endfunction

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int DEBOUNCE_MS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic raw_n,
    output logic held,
    output logic press_p,
    output logic release_p
);
    localparam int CW = $clog2(DEBOUNCE_MS + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            cnt_q     <= '0;
            held      <= 1'b0;
            press_p   <= 1'b0;
            release_p <= 1'b0;
        end else begin
            sync_q    <= {sync_q[0], ~raw_n};
            press_p   <= 1'b0;
            release_p <= 1'b0;
            if (sync_q[1] == held) begin
                cnt_q <= '0;
            end else if (ms_tick) begin
                if (cnt_q == CW'(DEBOUNCE_MS - 1)) begin
                    cnt_q     <= '0;
                    held      <= sync_q[1];
                    press_p   <= sync_q[1];
                    release_p <= ~sync_q[1];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hid_report_builder.sv
module hid_report_builder
    import btn_hid_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BTN-1:0] held,
    input  logic               btn_evt,
    input  logic               wr_en,
    input  logic               wr_odd,
    input  logic [7:0]         wr_data,
    input  logic               poll,
    output logic               pending,
    output hid_report_t        report
);
    logic [7:0] even_q, odd_q, even_n, odd_n;
    logic       evt;

    always_comb begin
        even_n = (wr_en && !wr_odd) ? wr_data : even_q;
        odd_n  = (wr_en &&  wr_odd) ? wr_data : odd_q;
        evt    = btn_evt | wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            even_q  <= '0;
            odd_q   <= '0;
            pending <= 1'b0;
            report  <= '0;
        end else begin
            even_q <= even_n;
            odd_q  <= odd_n;
            if (evt) begin
                pending <= 1'b1;
                report  <= pack_report(held, even_n, odd_n);
            end else if (poll) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/led_blinker.sv
module led_blinker #(
    parameter int HALF_MS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic active,
    output logic led
);
    localparam int CW = $clog2(HALF_MS + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
            led   <= 1'b0;
        end else if (ms_tick) begin
            if (cnt_q == CW'(HALF_MS - 1)) begin
                cnt_q <= '0;
                led   <= ~led;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/btn_hid_reporter.sv
module btn_hid_reporter
    import btn_hid_pkg::*;
#(
    parameter int DEBOUNCE_MS   = 64,
    parameter int BLINK_HALF_MS = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ms_tick,
    input  logic [NUM_BTN-1:0] btn_n,
    input  logic               reg_wr_en,
    input  logic               reg_wr_odd,
    input  logic [7:0]         reg_wr_data,
    input  logic               host_poll,
    input  logic               suspended,
    input  logic               stream_active,
    output logic               rpt_pending,
    output logic [23:0]        rpt_data,
    output logic               rec_mute_led,
    output logic               act_led,
    output logic               wake_req
);
    logic [NUM_BTN-1:0] held, press_p, release_p;
    logic               any_press, any_edge;
    hid_report_t        report;

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
        btn_debounce #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_deb (
            .clk       (clk),
            .rst       (rst),
            .ms_tick   (ms_tick),
            .raw_n     (btn_n[i]),
            .held      (held[i]),
            .press_p   (press_p[i]),
            .release_p (release_p[i])
        );
    end

    assign any_press = |press_p;
    assign any_edge  = |(press_p | release_p);

    hid_report_builder u_rpt (
        .clk     (clk),
        .rst     (rst),
        .held    (held),
        .btn_evt (any_edge),
        .wr_en   (reg_wr_en),
        .wr_odd  (reg_wr_odd),
        .wr_data (reg_wr_data),
        .poll    (host_poll),
        .pending (rpt_pending),
        .report  (report)
    );
    assign rpt_data = report;

    led_blinker #(.HALF_MS(BLINK_HALF_MS)) u_blink (
        .clk     (clk),
        .rst     (rst),
        .ms_tick (ms_tick),
        .active  (stream_active),
        .led     (act_led)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_mute_led <= 1'b0;
            wake_req     <= 1'b0;
        end else begin
            if (press_p[BTN_RMUT])
                rec_mute_led <= ~rec_mute_led;
            wake_req <= suspended & (wake_req | any_press);
        end
    end
endmodule

// File: rtl/btn_hid_reporter_chk.sv
module btn_hid_reporter_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  press_p,
    input logic [3:0]  release_p,
    input logic [3:0]  held,
    input logic        reg_wr_en,
    input logic        reg_wr_odd,
    input logic [7:0]  reg_wr_data,
    input logic        host_poll,
    input logic        suspended,
    input logic        stream_active,
    input logic        rpt_pending,
    input logic [23:0] rpt_data,
    input logic        rec_mute_led,
    input logic        act_led,
    input logic        wake_req
);
    // R2
    held_change_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(held) |-> |(press_p | release_p));

    // R3
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_data[7:4] == 4'h0);

    // R4
    edge_queues_chk: assert property (@(posedge clk) disable iff (rst)
        |(press_p | release_p) |=> rpt_pending);

    // R5
    even_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !reg_wr_odd) |=> (rpt_pending && rpt_data[15:8] == $past(reg_wr_data)));

    // R6
    odd_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_odd) |=> (rpt_pending && rpt_data[23:16] == $past(reg_wr_data)));

    // R7
    poll_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (host_poll && !reg_wr_en && !(|(press_p | release_p))) |=> !rpt_pending);

    // R8
    rec_press_toggles_chk: assert property (@(posedge clk) disable iff (rst)
        press_p[3] |=> (rec_mute_led != $past(rec_mute_led)));

    // R9
    idle_led_off_chk: assert property (@(posedge clk) disable iff (rst)
        !stream_active |=> !act_led);

    // R10
    wake_needs_suspend_chk: assert property (@(posedge clk) disable iff (rst)
        !suspended |=> !wake_req);

    // R10
    wake_on_press_chk: assert property (@(posedge clk) disable iff (rst)
        (suspended && |press_p) |=> wake_req);
endmodule

bind btn_hid_reporter btn_hid_reporter_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .press_p       (press_p),
    .release_p     (release_p),
    .held          (held),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_odd    (reg_wr_odd),
    .reg_wr_data   (reg_wr_data),
    .host_poll     (host_poll),
    .suspended     (suspended),
    .stream_active (stream_active),
    .rpt_pending   (rpt_pending),
    .rpt_data      (rpt_data),
    .rec_mute_led  (rec_mute_led),
    .act_led       (act_led),
    .wake_req      (wake_req)
);

// File: tb/btn_hid_reporter_tb.sv
`timescale 1ns/1ps
module btn_hid_reporter_tb;
    localparam int TICK_DIV = 4;
    localparam int DEB      = 64;
    localparam int SETTLE   = DEB * TICK_DIV + 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic [3:0]  btn_n = 4'hF;
    logic        reg_wr_en = 1'b0, reg_wr_odd = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic        host_poll = 1'b0, suspended = 1'b0, stream_active = 1'b0;
    logic        rpt_pending, rec_mute_led, act_led, wake_req;
    logic [23:0] rpt_data;

    int tests = 0, fails = 0;
    logic [3:0] m_held = '0;
    logic [7:0] m_even = '0, m_odd = '0;
    logic       m_mute = 1'b0;

    always #2 clk = ~clk;

    int tick_cnt = 0;
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        ms_tick  <= (tick_cnt == TICK_DIV - 1);
    end

    btn_hid_reporter u_dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .btn_n(btn_n),
        .reg_wr_en(reg_wr_en), .reg_wr_odd(reg_wr_odd), .reg_wr_data(reg_wr_data),
        .host_poll(host_poll), .suspended(suspended), .stream_active(stream_active),
        .rpt_pending(rpt_pending), .rpt_data(rpt_data),
        .rec_mute_led(rec_mute_led), .act_led(act_led), .wake_req(wake_req)
    );

    function automatic logic [23:0] exp_report();
        return {m_odd, m_even, 4'h0, m_held};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_btn(input int i, input logic down);
        @(negedge clk);
        btn_n[i] = ~down;
        wait_cyc(SETTLE);
        if (down && !m_held[i] && i == 3) m_mute = ~m_mute;
        m_held[i] = down;
    endtask

    task automatic reg_write(input logic odd, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_odd = odd; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (odd) m_odd = d; else m_even = d;
    endtask

    task automatic do_poll();
        @(negedge clk);
        host_poll = 1'b1;
        @(negedge clk);
        host_poll = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1 reset state
        check("R1 pending", {31'd0, rpt_pending}, 32'd0);
        check("R1 data", {8'd0, rpt_data}, 32'd0);
        check("R1 leds/wake", {29'd0, rec_mute_led, act_led, wake_req}, 32'd0);

        // R2 glitch shorter than window: no effect
        @(negedge clk);
        btn_n[1] = 1'b0;
        wait_cyc((DEB / 2) * TICK_DIV);
        btn_n[1] = 1'b1;
        wait_cyc(SETTLE);
        check("R2 glitch pending", {31'd0, rpt_pending}, 32'd0);
        check("R2 glitch status", {8'd0, rpt_data}, 32'd0);

        // R2 not yet accepted just before window expires
        @(negedge clk);
        btn_n[0] = 1'b0;
        wait_cyc((DEB - 4) * TICK_DIV);
        check("R2 early", {31'd0, rpt_pending}, 32'd0);
        wait_cyc(80);
        m_held[0] = 1'b1;
        // R3 R4 R6 press of vol up
        check("R4 press queues", {31'd0, rpt_pending}, 32'd1);
        check("R3 R6 status bit0", {8'd0, rpt_data}, {8'd0, exp_report()});
        do_poll();
        check("R7 poll clears", {31'd0, rpt_pending}, 32'd0);
        set_btn(0, 1'b0);
        check("R4 release queues", {31'd0, rpt_pending}, 32'd1);
        check("R3 release status", {8'd0, rpt_data}, {8'd0, exp_report()});
        do_poll();

        // R5 R6 register bytes
        reg_write(1'b0, 8'h5A);
        check("R5 even write", {8'd0, rpt_data}, {8'd0, exp_report()});
        reg_write(1'b1, 8'hC3);
        check("R7 overwrite R6", {8'd0, rpt_data}, {8'd0, exp_report()});
        check("R5 pending", {31'd0, rpt_pending}, 32'd1);

        // R7 poll and write in the same cycle: event wins
        @(negedge clk);
        host_poll = 1'b1; reg_wr_en = 1'b1; reg_wr_odd = 1'b0; reg_wr_data = 8'h99;
        @(negedge clk);
        host_poll = 1'b0; reg_wr_en = 1'b0; m_even = 8'h99;
        check("R7 same-cycle pending", {31'd0, rpt_pending}, 32'd1);
        check("R7 same-cycle data", {8'd0, rpt_data}, {8'd0, exp_report()});
        do_poll();
        check("R7 lone poll", {31'd0, rpt_pending}, 32'd0);

        // R8 record mute toggles on press only
        set_btn(3, 1'b1);
        check("R8 mute on", {31'd0, rec_mute_led}, {31'd0, m_mute});
        set_btn(3, 1'b0);
        check("R8 release keeps", {31'd0, rec_mute_led}, {31'd0, m_mute});
        do_poll();

        // R10 wake only while suspended
        set_btn(2, 1'b1);
        check("R10 no wake awake", {31'd0, wake_req}, 32'd0);
        set_btn(2, 1'b0);
        @(negedge clk); suspended = 1'b1;
        set_btn(1, 1'b1);
        check("R10 wake set", {31'd0, wake_req}, 32'd1);
        set_btn(1, 1'b0);
        check("R10 wake held", {31'd0, wake_req}, 32'd1);
        @(negedge clk); suspended = 1'b0;
        wait_cyc(2);
        check("R10 wake cleared", {31'd0, wake_req}, 32'd0);
        do_poll();

        // R9 activity LED
        @(negedge clk); stream_active = 1'b1;
        begin
            int toggles = 0;
            logic prev;
            prev = act_led;
            for (int c = 0; c < 2100; c++) begin
                @(negedge clk);
                if (act_led !== prev) toggles++;
                prev = act_led;
            end
            check("R9 toggle count", toggles, 32'd4);
        end
        @(negedge clk); stream_active = 1'b0;
        wait_cyc(2);
        check("R9 idle off", {31'd0, act_led}, 32'd0);

        // Random mix: R2 R3 R4 R5 R6 R7 R8
        for (int it = 0; it < 24; it++) begin
            int op;
            op = $urandom % 3;
            if (op == 0) begin
                int b;
                b = $urandom % 4;
                set_btn(b, ~m_held[b]);
            end else if (op == 1) begin
                reg_write(1'($urandom), 8'($urandom));
            end else begin
                reg_write(1'b0, m_even);
                set_btn(0, ~m_held[0]);
            end
            check("R4 R5 random pending", {31'd0, rpt_pending}, 32'd1);
            check("R6 random data", {8'd0, rpt_data}, {8'd0, exp_report()});
            check("R8 random mute", {31'd0, rec_mute_led}, {31'd0, m_mute});
            do_poll();
            check("R7 random poll", {31'd0, rpt_pending}, 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule